// File: doc/BRIEF.md
# Addressable Bit Register with Demultiplexer

This block keeps a small bank of single-bit storage elements. Each element is picked by a binary address, and a serial data bit is written into the picked element. Two active-low control inputs choose one of four modes each cycle:

- **Write-one-bit:** updates only the addressed element.
- **Hold:** freezes the whole bank.
- **Decode:** leaves only the addressed output able to follow the data bit and forces every other output low, so the block acts as a 1-to-N demultiplexer.
- **Clear:** drives every output low.

Every input is sampled on the rising clock edge, and the outputs come straight from the storage flops. A system uses the block to assemble a parallel word one bit at a time from scattered writes. It can also use it as a registered binary-to-one-hot decoder with a data gate.

The address may only change in a hold cycle. If several address bits change while a write or decode is in progress, the wrong element could be touched. The design flags this in simulation.

Top module: `addr_latch_demux`

## Requirements
- R1: While the synchronous reset `rst_n` is low at a rising edge, all outputs `q` are 0 after that edge.
- R2: In write-one-bit mode, the element selected by `addr` takes `din` and every other element keeps its value.
- R3: In hold mode, all elements keep their values whatever `din` and `addr` do.
- R4: In decode mode, the addressed output becomes `din` and all other outputs become 0.
- R5: In clear mode, all outputs become 0 regardless of `addr` and `din`.
- R6: Mode encoding as {`en_n`,`clr_n`}:
  - 2'b01 selects write-one-bit.
  - 2'b11 selects hold.
  - 2'b00 selects decode.
  - 2'b10 selects clear.
- R7: Address value k selects output bit `q[k]`; `addr` = 0 selects `q[0]`.
- R8: The inputs are sampled on a rising edge, and the result shows on `q` after that same edge. It stays there until the next edge.
- R9: `addr` may change only in a cycle whose mode is hold. A change in any other mode is reported as a protocol violation. A write that follows an address change made in hold uses the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, clears all elements |
| en_n | input | 1 | Active-low enable control |
| clr_n | input | 1 | Active-low clear control |
| din | input | 1 | Data bit |
| addr | input | ADDR_W (3) | Element address |
| q | output | 2**ADDR_W (8) | Stored bits, active high |

## Verification
The outputs are the storage flops themselves, so a wrong element value shows on `q` right after the edge that caused it. The scoreboard compares the whole word every cycle, so the error is caught in that cycle.

A wrong bit that the element would normally keep, for example a stray write to a neighbour or a leak during hold, stays visible until a clear, decode or reset overwrites it. Random runs of all four modes, checked on every cycle, bring such a bit into view within a few cycles.

// File: rtl/al_pkg.sv
// Shared types for the addressable bit register.
// Assumes a two-bit mode code decoded from two active-low controls.
package al_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE  = 2'd0,
        MODE_HOLD   = 2'd1,
        MODE_DECODE = 2'd2,
        MODE_CLEAR  = 2'd3
    } al_mode_e;
endpackage

// File: rtl/al_mode_decode.sv
// Maps the two active-low controls to an operating mode.
// Assumes the controls are already synchronous to clk.
module al_mode_decode
    import al_pkg::*;
(
    input  logic     en_n,
    input  logic     clr_n,
    output al_mode_e mode
);
    // Purpose: translate {en_n, clr_n} into the mode code (R6).
    always_comb begin
        unique case ({en_n, clr_n})
            2'b01:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DECODE;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/al_addr_decode.sv
// Binary address to one-hot select, bit k set for address k.
// Assumes NBITS equals 2**ADDR_W.
module al_addr_decode #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NBITS-1:0]  sel
);
    for (genvar k = 0; k < NBITS; k++) begin : g_sel
        // Purpose: raise select line k when the address equals k (R7).
        always_comb sel[k] = (addr == ADDR_W'(k));
    end
endmodule

// File: rtl/al_store_bank.sv
// Bank of storage flops.
// Each element takes its next value from the mode, its select line and din.
// Assumes sel is one-hot and mode is decoded in the same cycle.
module al_store_bank
    import al_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  al_mode_e         mode,
    input  logic [NBITS-1:0] sel,
    input  logic             din,
    output logic [NBITS-1:0] q
);
    logic [NBITS-1:0] q_nxt;

    for (genvar i = 0; i < NBITS; i++) begin : g_elem
        // Purpose: choose the next value of element i from the current mode.
        always_comb begin
            unique case (mode)
                MODE_WRITE:  q_nxt[i] = sel[i] ? din : q[i];
                MODE_HOLD:   q_nxt[i] = q[i];
                MODE_DECODE: q_nxt[i] = sel[i] & din;
                default:     q_nxt[i] = 1'b0;
            endcase
        end
    end

    // Purpose: register the bank with a synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (q == '0)); // R1
    AST_WRITE_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE) |=> ((q & ~$past(sel)) == ($past(q) & ~$past(sel)))); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(q)); // R3
    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DECODE) |=> $onehot0(q)); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CLEAR) |=> (q == '0)); // R5
endmodule

// File: rtl/addr_latch_demux.sv
// Addressable bit register with a decode mode.
// Four modes come from two active-low controls; all inputs are sampled on the
// rising edge. Assumes addr changes only in hold cycles.
module addr_latch_demux
    import al_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              clr_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    output logic [NBITS-1:0]  q
);
    al_mode_e         mode;
    logic [NBITS-1:0] sel;

    al_mode_decode u_mode (
        .en_n  (en_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    al_addr_decode #(.ADDR_W(ADDR_W)) u_sel (
        .addr (addr),
        .sel  (sel)
    );

    al_store_bank #(.NBITS(NBITS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .sel   (sel),
        .din   (din),
        .q     (q)
    );

    AST_ADDR_ONLY_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_HOLD) |-> $stable(addr)); // R9
    AST_DECODE_HITS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DECODE) |=> (q[$past(addr)] == $past(din))); // R7
endmodule

// File: tb/addr_latch_demux_tb.sv
module addr_latch_demux_tb;
    localparam int ADDR_W = 3;
    localparam int NBITS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_n = 1'b1;
    logic              clr_n = 1'b1;
    logic              din = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [NBITS-1:0]  q;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [NBITS-1:0] model = '0;
    logic [NBITS-1:0] exp_q[$];
    string            tag_q[$];

    always #5 clk = ~clk;

    addr_latch_demux #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .clr_n(clr_n),
        .din(din), .addr(addr), .q(q)
    );

    // Driver: apply one cycle of inputs at the falling edge and push the expected word.
    task automatic step(input logic r, input logic e, input logic c,
                        input logic [ADDR_W-1:0] a, input logic d, input string tag);
        @(negedge clk);
        rst_n = r; en_n = e; clr_n = c; addr = a; din = d;
        if (!r) model = '0;
        else begin
            case ({e, c})
                2'b01: model[a] = d;
                2'b11: model = model;
                2'b00: model = d ? (NBITS'(1) << a) : '0;
                default: model = '0;
            endcase
        end
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare q shortly after every rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [NBITS-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (q !== e) begin
                    n_fail++;
                    $display("FAIL %s: q=%b expected=%b at %0t", t, q, e, $time);
                end
            end
        end
    end

    // Hold cycle that also moves the address (the only legal time to move it).
    task automatic seek(input logic [ADDR_W-1:0] a, input logic d);
        step(1'b1, 1'b1, 1'b1, a, d, "R9 hold-seek");
    endtask

    initial begin
        // R1: reset clears
        repeat (3) step(1'b0, 1'b1, 1'b1, '0, 1'b1, "R1 reset");
        step(1'b1, 1'b1, 1'b1, '0, 1'b0, "R1 after reset");

        // R2/R7/R8: write a pattern one bit at a time
        for (int k = 0; k < NBITS; k++) begin
            seek(ADDR_W'(k), 1'b0);
            step(1'b1, 1'b0, 1'b1, ADDR_W'(k), (k % 3 != 1), "R2 R7 R8 write");
        end
        // R2: overwrite one bit, neighbours kept
        seek(3'd4, 1'b1);
        step(1'b1, 1'b0, 1'b1, 3'd4, 1'b0, "R2 overwrite");

        // R3: hold ignores din and addr movement
        for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b1, ADDR_W'(k * 3), k[0], "R3 hold");

        // R4: decode mode
        seek(3'd5, 1'b0);
        step(1'b1, 1'b0, 1'b0, 3'd5, 1'b1, "R4 decode one");
        step(1'b1, 1'b0, 1'b0, 3'd5, 1'b0, "R4 decode zero");
        seek(3'd0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R4 R7 decode addr0");
        step(1'b1, 1'b1, 1'b1, 3'd6, 1'b0, "R4 R3 hold after decode");

        // R5: clear regardless of din/addr
        seek(3'd7, 1'b1);
        step(1'b1, 1'b0, 1'b1, 3'd7, 1'b1, "R2 write before clear");
        step(1'b1, 1'b1, 1'b0, 3'd7, 1'b1, "R5 clear");
        seek(3'd2, 1'b1);
        step(1'b1, 1'b1, 1'b0, 3'd2, 1'b0, "R5 clear again");

        // R6: each control combination from a known state
        seek(3'd3, 1'b1);
        step(1'b1, 1'b0, 1'b1, 3'd3, 1'b1, "R6 code 01 write");
        step(1'b1, 1'b1, 1'b1, 3'd3, 1'b0, "R6 code 11 hold");
        step(1'b1, 1'b0, 1'b0, 3'd3, 1'b1, "R6 code 00 decode");
        step(1'b1, 1'b1, 1'b0, 3'd3, 1'b1, "R6 code 10 clear");

        // Random mixed modes; the address moves only in hold cycles (R9)
        for (int n = 0; n < 400; n++) begin
            logic [1:0] m;
            logic [ADDR_W-1:0] a;
            m = 2'($urandom_range(0, 3));
            a = (m == 2'b11) ? ADDR_W'($urandom) : addr;
            case (m)
                2'b01:   step(1'b1, m[1], m[0], a, 1'($urandom), "R2 random write");
                2'b11:   step(1'b1, m[1], m[0], a, 1'($urandom), "R3 random hold");
                2'b00:   step(1'b1, m[1], m[0], a, 1'($urandom), "R4 random decode");
                default: step(1'b1, m[1], m[0], a, 1'($urandom), "R5 random clear");
            endcase
        end

        // Reset in the middle of a run
        seek(3'd1, 1'b1);
        step(1'b1, 1'b0, 1'b1, 3'd1, 1'b1, "R2 write before reset");
        step(1'b0, 1'b0, 1'b1, 3'd1, 1'b1, "R1 reset over write");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: q=%b expected=done", q);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule